// File: doc/BRIEF.md
# TCP Handshake Tracker

This block follows one TCP connection segment by segment. For each segment it looks at the flag bits and at which side sent it. From these it steps through the three-way opening exchange and then into a data phase. It also keeps the most recent segment's header context in registers, so that downstream reassembly and steering logic can use it. Downstream units receive a steering bit that gives the segment's origin, an alarm pulse with a cause code, an indication that the connection is open, and one-cycle strobes that mark when the peer window has been captured.

Suspicious flag combinations of the kind used by stealth port scans raise the alarm without moving the connection state. A connection that stays half-open longer than a programmable number of cycles is dropped back to the idle state, and it raises the alarm with a separate cause. A reset segment closes the connection from any state.

Top module: `tcp_hs_tracker`

## Requirements
- R1: After a synchronous active-low reset, `conn_state` is 0, and `established`, `flag_vuln`, `vuln_cause`, `division`, both window strobes, `peer_window`, both ISNs and all context outputs are 0. The state codes are: 0 idle, 1 SYN sent, 2 SYN received, 3 established, 4 exchange.
- R2: In state 0, a client-side segment (`seg_from_client`=1) with SYN (flag bit 1) set and ACK (bit 4), FIN (bit 0) and RST (bit 2) clear moves the state to 1 at the next clock edge and stores its sequence number in `client_isn`.
- R3: In state 1, a server-side segment with SYN and ACK set and FIN and RST clear moves the state to 2. It stores its sequence number in `server_isn` and its window in `peer_window`, and it pulses `win_strobe_synrecv` for exactly one cycle.
- R4: In state 2, a client-side segment with ACK set and SYN and RST clear moves the state to 3. It stores its window in `peer_window` and pulses `win_strobe_est` for one cycle. `established` is 1 exactly in states 3 and 4.
- R5: In state 3, a segment with `seg_len` not zero moves the state to 4. A zero-length segment leaves the state at 3.
- R6: A segment without RST whose flags are all zero, or that has FIN without ACK, or that has SYN and FIN together, pulses `flag_vuln` for one cycle with `vuln_cause`=1 in any state, and it leaves the state unchanged.
- R7: A segment that fits neither the expected step (wrong side or wrong flags) nor R6 nor R9 leaves the state unchanged and raises no alarm.
- R8: With `cfg_halfopen_limit`=T>0, a connection that enters state 1 or 2 and makes no further transition reads that state for T cycles. At the following edge it returns to 0 with a one-cycle `flag_vuln` and `vuln_cause`=2. This expiry takes precedence over any segment except one with RST. T=0 disables the timeout.
- R9: A segment with RST set returns the state to 0 from any state, with `established` low and no alarm. It takes precedence over every other rule.
- R10: One cycle after each valid segment, `division` equals that segment's `seg_from_client` (1 client side, 0 server side), and the context outputs hold its addresses, ports, sequence, acknowledgment, window, TTL and flags. They hold those values until the next valid segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_halfopen_limit | input | TMR_W | Half-open timeout in cycles, 0 disables it |
| seg_valid | input | 1 | A segment header is present this cycle |
| seg_from_client | input | 1 | 1 if the segment comes from the client side |
| seg_flags | input | 6 | TCP flags: bit0 FIN, bit1 SYN, bit2 RST, bit3 PSH, bit4 ACK, bit5 URG |
| seg_src_addr | input | 32 | Source IP address |
| seg_dst_addr | input | 32 | Destination IP address |
| seg_src_port | input | 16 | Source port |
| seg_dst_port | input | 16 | Destination port |
| seg_seq | input | 32 | Sequence number |
| seg_ack | input | 32 | Acknowledgment number |
| seg_win | input | 16 | Advertised window |
| seg_ttl | input | 8 | IP time to live |
| seg_len | input | 16 | Payload length in bytes |
| conn_state | output | 3 | Connection state code |
| established | output | 1 | Connection open (states 3 and 4) |
| division | output | 1 | Steering bit: origin of the last segment |
| flag_vuln | output | 1 | One-cycle alarm pulse |
| vuln_cause | output | 2 | 1 scan pattern, 2 half-open timeout, 0 with no alarm |
| win_strobe_synrecv | output | 1 | Window captured on entry to state 2 |
| win_strobe_est | output | 1 | Window captured on entry to state 3 |
| peer_window | output | 16 | Last captured window |
| client_isn | output | 32 | Client initial sequence number |
| server_isn | output | 32 | Server initial sequence number |
| ctx_src_addr | output | 32 | Held source address |
| ctx_dst_addr | output | 32 | Held destination address |
| ctx_src_port | output | 16 | Held source port |
| ctx_dst_port | output | 16 | Held destination port |
| ctx_seq | output | 32 | Held sequence number |
| ctx_ack | output | 32 | Held acknowledgment number |
| ctx_win | output | 16 | Held window |
| ctx_ttl | output | 8 | Held TTL |
| ctx_flags | output | 6 | Held flags |

## Verification
Several rules are checked by assertions on every cycle. These are the legality of the state code, closure after a reset segment, an unmoved state with cause 1 after a scan pattern, closure with cause 2 after an expiry, mutual exclusion of the two window strobes, and entry to the exchange state only from the established state. The bench scenarios are what show the full handshake path and the captured ISN and window values. They also show the exact half-open dwell length, the disabled timeout, the segments that are ignored, and the context held for steering. A random segment mix compared against a bench model covers orderings that the directed cases miss.

// File: rtl/hs_pkg.sv
// Package: shared constants and types for the TCP handshake tracker.
// Assumes the standard TCP flag bit order in a 6-bit flag field.
package hs_pkg;

    localparam int FLAG_W  = 6;
    localparam int FL_FIN  = 0;
    localparam int FL_SYN  = 1;
    localparam int FL_RST  = 2;
    localparam int FL_PSH  = 3;
    localparam int FL_ACK  = 4;
    localparam int FL_URG  = 5;

    localparam int ADDR_W  = 32;
    localparam int PORT_W  = 16;
    localparam int SEQ_W   = 32;
    localparam int WIN_W   = 16;
    localparam int TTL_W   = 8;
    localparam int LEN_W   = 16;
    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE     = 3'd0,
        ST_SYN_SENT = 3'd1,
        ST_SYN_RECV = 3'd2,
        ST_EST      = 3'd3,
        ST_EXCH     = 3'd4
    } conn_state_e;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_SCAN = 2'd1,
        CAUSE_HALF = 2'd2
    } vuln_cause_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src_addr;
        logic [ADDR_W-1:0] dst_addr;
        logic [PORT_W-1:0] src_port;
        logic [PORT_W-1:0] dst_port;
        logic [SEQ_W-1:0]  seq;
        logic [SEQ_W-1:0]  ack;
        logic [WIN_W-1:0]  win;
        logic [TTL_W-1:0]  ttl;
        logic [FLAG_W-1:0] flags;
        logic              from_client;
    } seg_ctx_t;

endpackage

// File: rtl/hs_flag_decode.sv
// Module: hs_flag_decode
// Classifies one segment's flag field into the events the tracker reacts to.
// Purely combinational; the caller qualifies the results with its valid strobe.
module hs_flag_decode
    import hs_pkg::*;
(
    input  logic [FLAG_W-1:0] flags,
    output logic              is_rst,
    output logic              is_scan,
    output logic              is_syn_open,
    output logic              is_syn_ack,
    output logic              is_plain_ack
);

    logic fin, syn, rst, ackb;

    // Pick out the flag bits that matter for the handshake
    always_comb begin
        fin  = flags[FL_FIN];
        syn  = flags[FL_SYN];
        rst  = flags[FL_RST];
        ackb = flags[FL_ACK];
    end

    // Derive event classes; the scan patterns never include RST
    always_comb begin
        is_rst       = rst;
        is_scan      = !rst && ((flags == '0) || (fin && !ackb) || (syn && fin));
        is_syn_open  = syn && !ackb && !fin && !rst;
        is_syn_ack   = syn && ackb && !fin && !rst;
        is_plain_ack = ackb && !syn && !rst;
    end

endmodule

// File: rtl/hs_seg_capture.sv
// Module: hs_seg_capture
// Holds the header context of the most recent valid segment for downstream use.
// Assumes the valid strobe marks every cycle that carries a real segment.
module hs_seg_capture
    import hs_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     valid,
    input  seg_ctx_t seg_in,
    output seg_ctx_t ctx_q
);

    // Register the full context on each valid segment, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else if (valid) begin
            ctx_q <= seg_in;
        end
    end

    // The held context must follow the last valid segment
    AST_CTX_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> ctx_q.seq == $past(seg_in.seq)); // R10

endmodule

// File: rtl/hs_halfopen_timer.sv
// Module: hs_halfopen_timer
// Counts the cycles spent in a half-open state and flags expiry.
// Assumes the caller supplies the current and next half-open status and a
// restart whenever the state changes. A limit of zero disables expiry.
module hs_halfopen_timer #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             next_active,
    input  logic             restart,
    input  logic [TMR_W-1:0] limit,
    output logic             expire
);

    localparam logic [TMR_W-1:0] CNT_MAX = {TMR_W{1'b1}};
    localparam logic [TMR_W-1:0] ONE     = {{(TMR_W-1){1'b0}}, 1'b1};

    logic [TMR_W-1:0] cnt_q;

    // Expiry fires in the last cycle of the allowed dwell
    always_comb begin
        expire = active && (limit != '0) && (cnt_q >= (limit - ONE));
    end

    // Count dwell cycles, clearing on a state change or outside half-open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !next_active) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // A running count only exists while the connection is half-open
    AST_TMR_ONLY_HALFOPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> active); // R8

endmodule

// File: rtl/tcp_hs_tracker.sv
// Module: tcp_hs_tracker (top)
// Follows the opening handshake and data phase of a single TCP connection.
// It drives steering, alarm, open and window-capture outputs and holds the
// last segment's context. Assumes segments of one connection only, one per cycle.
module tcp_hs_tracker
    import hs_pkg::*;
#(
    parameter int TMR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMR_W-1:0]  cfg_halfopen_limit,
    input  logic              seg_valid,
    input  logic              seg_from_client,
    input  logic [5:0]        seg_flags,
    input  logic [31:0]       seg_src_addr,
    input  logic [31:0]       seg_dst_addr,
    input  logic [15:0]       seg_src_port,
    input  logic [15:0]       seg_dst_port,
    input  logic [31:0]       seg_seq,
    input  logic [31:0]       seg_ack,
    input  logic [15:0]       seg_win,
    input  logic [7:0]        seg_ttl,
    input  logic [15:0]       seg_len,
    output logic [2:0]        conn_state,
    output logic              established,
    output logic              division,
    output logic              flag_vuln,
    output logic [1:0]        vuln_cause,
    output logic              win_strobe_synrecv,
    output logic              win_strobe_est,
    output logic [15:0]       peer_window,
    output logic [31:0]       client_isn,
    output logic [31:0]       server_isn,
    output logic [31:0]       ctx_src_addr,
    output logic [31:0]       ctx_dst_addr,
    output logic [15:0]       ctx_src_port,
    output logic [15:0]       ctx_dst_port,
    output logic [31:0]       ctx_seq,
    output logic [31:0]       ctx_ack,
    output logic [15:0]       ctx_win,
    output logic [7:0]        ctx_ttl,
    output logic [5:0]        ctx_flags
);

    conn_state_e state_q, state_d;
    logic        dec_rst, dec_scan, dec_syn_open, dec_syn_ack, dec_plain_ack;
    logic        ev_rst, ev_scan, tmr_expire;
    logic        load_cisn, load_sisn, load_win;
    logic        vuln_d, strobe_sr_d, strobe_est_d;
    vuln_cause_e cause_d, cause_q;
    logic        vuln_q, strobe_sr_q, strobe_est_q;
    logic [WIN_W-1:0] win_q;
    logic [SEQ_W-1:0] cisn_q, sisn_q;
    seg_ctx_t    seg_bundle, ctx_q;
    logic        half_now, half_next, state_change;

    hs_flag_decode u_dec (
        .flags        (seg_flags),
        .is_rst       (dec_rst),
        .is_scan      (dec_scan),
        .is_syn_open  (dec_syn_open),
        .is_syn_ack   (dec_syn_ack),
        .is_plain_ack (dec_plain_ack)
    );

    // Bundle the incoming header fields for the context register
    always_comb begin
        seg_bundle.src_addr    = seg_src_addr;
        seg_bundle.dst_addr    = seg_dst_addr;
        seg_bundle.src_port    = seg_src_port;
        seg_bundle.dst_port    = seg_dst_port;
        seg_bundle.seq         = seg_seq;
        seg_bundle.ack         = seg_ack;
        seg_bundle.win         = seg_win;
        seg_bundle.ttl         = seg_ttl;
        seg_bundle.flags       = seg_flags;
        seg_bundle.from_client = seg_from_client;
    end

    hs_seg_capture u_cap (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (seg_valid),
        .seg_in (seg_bundle),
        .ctx_q  (ctx_q)
    );

    hs_halfopen_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (half_now),
        .next_active (half_next),
        .restart     (state_change),
        .limit       (cfg_halfopen_limit),
        .expire      (tmr_expire)
    );

    // Qualify decoded events with the valid strobe
    always_comb begin
        ev_rst  = seg_valid && dec_rst;
        ev_scan = seg_valid && dec_scan;
    end

    // Next-state logic: reset segment, then expiry, then scan hold, then handshake steps
    always_comb begin
        state_d   = state_q;
        load_cisn = 1'b0;
        load_sisn = 1'b0;
        load_win  = 1'b0;
        if (ev_rst) begin
            state_d = ST_IDLE;
        end else if (tmr_expire) begin
            state_d = ST_IDLE;
        end else if (ev_scan) begin
            state_d = state_q;
        end else if (seg_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (seg_from_client && dec_syn_open) begin
                        state_d   = ST_SYN_SENT;
                        load_cisn = 1'b1;
                    end
                end
                ST_SYN_SENT: begin
                    if (!seg_from_client && dec_syn_ack) begin
                        state_d   = ST_SYN_RECV;
                        load_sisn = 1'b1;
                        load_win  = 1'b1;
                    end
                end
                ST_SYN_RECV: begin
                    if (seg_from_client && dec_plain_ack) begin
                        state_d  = ST_EST;
                        load_win = 1'b1;
                    end
                end
                ST_EST: begin
                    if (seg_len != '0) begin
                        state_d = ST_EXCH;
                    end
                end
                default: state_d = state_q;
            endcase
        end
    end

    // Alarm, cause and strobe decisions for the next cycle
    always_comb begin
        vuln_d       = !ev_rst && (tmr_expire || ev_scan);
        cause_d      = !vuln_d ? CAUSE_NONE : (tmr_expire ? CAUSE_HALF : CAUSE_SCAN);
        strobe_sr_d  = (state_d == ST_SYN_RECV) && (state_q == ST_SYN_SENT);
        strobe_est_d = (state_d == ST_EST) && (state_q == ST_SYN_RECV);
    end

    // Half-open status now and next, plus a state-change pulse for the timer
    always_comb begin
        half_now     = (state_q == ST_SYN_SENT) || (state_q == ST_SYN_RECV);
        half_next    = (state_d == ST_SYN_SENT) || (state_d == ST_SYN_RECV);
        state_change = (state_d != state_q);
    end

    // Connection state and alarm registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            vuln_q       <= 1'b0;
            cause_q      <= CAUSE_NONE;
            strobe_sr_q  <= 1'b0;
            strobe_est_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            vuln_q       <= vuln_d;
            cause_q      <= cause_d;
            strobe_sr_q  <= strobe_sr_d;
            strobe_est_q <= strobe_est_d;
        end
    end

    // Sequence-number and window capture registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cisn_q <= '0;
            sisn_q <= '0;
            win_q  <= '0;
        end else begin
            if (load_cisn) cisn_q <= seg_seq;
            if (load_sisn) sisn_q <= seg_seq;
            if (load_win)  win_q  <= seg_win;
        end
    end

    // Drive the output ports from the registered state
    always_comb begin
        conn_state         = state_q;
        established        = (state_q == ST_EST) || (state_q == ST_EXCH);
        division           = ctx_q.from_client;
        flag_vuln          = vuln_q;
        vuln_cause         = cause_q;
        win_strobe_synrecv = strobe_sr_q;
        win_strobe_est     = strobe_est_q;
        peer_window        = win_q;
        client_isn         = cisn_q;
        server_isn         = sisn_q;
        ctx_src_addr       = ctx_q.src_addr;
        ctx_dst_addr       = ctx_q.dst_addr;
        ctx_src_port       = ctx_q.src_port;
        ctx_dst_port       = ctx_q.dst_port;
        ctx_seq            = ctx_q.seq;
        ctx_ack            = ctx_q.ack;
        ctx_win            = ctx_q.win;
        ctx_ttl            = ctx_q.ttl;
        ctx_flags          = ctx_q.flags;
    end

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_q inside {ST_IDLE, ST_SYN_SENT, ST_SYN_RECV, ST_EST, ST_EXCH}); // R1
    AST_RST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_valid && seg_flags[FL_RST]) |=> (state_q == ST_IDLE) && !established && !flag_vuln); // R9
    AST_SCAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_scan && !tmr_expire) |=> flag_vuln && (vuln_cause == 2'd1) && $stable(state_q)); // R6
    AST_EXPIRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_expire && !ev_rst) |=> (state_q == ST_IDLE) && (vuln_cause == 2'd2)); // R8
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_strobe_synrecv && win_strobe_est)); // R3
    AST_SR_STROBE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        win_strobe_synrecv |-> (state_q == ST_SYN_RECV)); // R3
    AST_EXCH_FROM_EST: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_EXCH) && ($past(state_q) != ST_EXCH)) |-> ($past(state_q) == ST_EST)); // R5

endmodule

// File: tb/sim_tcp_hs_tracker.sv
`timescale 1ns/1ps
module sim_tcp_hs_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lim = 16'd5;
    logic        i_v = 1'b0, i_dir = 1'b0;
    logic [5:0]  i_flags = '0;
    logic [31:0] i_sa = '0, i_da = '0, i_seq = '0, i_ack = '0;
    logic [15:0] i_sp = '0, i_dp = '0, i_win = '0, i_len = '0;
    logic [7:0]  i_ttl = '0;

    logic [2:0]  conn_state;
    logic        established, division, flag_vuln, ws_sr, ws_est;
    logic [1:0]  vuln_cause;
    logic [15:0] peer_window, c_sp, c_dp, c_win;
    logic [31:0] client_isn, server_isn, c_sa, c_da, c_seq, c_ack;
    logic [7:0]  c_ttl;
    logic [5:0]  c_flags;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the connection tracker
    logic [2:0]  m_state = 0;
    logic [15:0] m_cnt = 0, m_win = 0;
    logic        m_vuln = 0, m_div = 0, m_ss = 0, m_se = 0;
    logic [1:0]  m_cause = 0;
    logic [31:0] m_cisn = 0, m_sisn = 0, m_seq = 0, m_sa = 0;
    logic [7:0]  m_ttl = 0;

    always #4 clk = ~clk;

    tcp_hs_tracker #(.TMR_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_halfopen_limit(lim),
        .seg_valid(i_v), .seg_from_client(i_dir), .seg_flags(i_flags),
        .seg_src_addr(i_sa), .seg_dst_addr(i_da), .seg_src_port(i_sp), .seg_dst_port(i_dp),
        .seg_seq(i_seq), .seg_ack(i_ack), .seg_win(i_win), .seg_ttl(i_ttl), .seg_len(i_len),
        .conn_state(conn_state), .established(established), .division(division),
        .flag_vuln(flag_vuln), .vuln_cause(vuln_cause),
        .win_strobe_synrecv(ws_sr), .win_strobe_est(ws_est), .peer_window(peer_window),
        .client_isn(client_isn), .server_isn(server_isn),
        .ctx_src_addr(c_sa), .ctx_dst_addr(c_da), .ctx_src_port(c_sp), .ctx_dst_port(c_dp),
        .ctx_seq(c_seq), .ctx_ack(c_ack), .ctx_win(c_win), .ctx_ttl(c_ttl), .ctx_flags(c_flags)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit is_scan_pat(input logic [5:0] f);
        return !f[2] && ((f == 6'd0) || (f[0] && !f[4]) || (f[1] && f[0]));
    endfunction

    // Advance the model by one clock using the inputs being driven
    task automatic model_step();
        logic half, expv, rst_e, scan;
        logic [2:0] ns;
        half  = (m_state == 3'd1) || (m_state == 3'd2);
        expv  = half && (lim != 0) && (m_cnt >= lim - 16'd1);
        rst_e = i_v && i_flags[2];
        scan  = i_v && is_scan_pat(i_flags);
        ns = m_state; m_ss = 0; m_se = 0;
        if (rst_e) ns = 0;
        else if (expv) ns = 0;
        else if (scan) ns = m_state;
        else if (i_v) begin
            case (m_state)
                3'd0: if (i_dir && i_flags[1] && !i_flags[4] && !i_flags[0]) begin ns = 1; m_cisn = i_seq; end
                3'd1: if (!i_dir && i_flags[1] && i_flags[4] && !i_flags[0]) begin
                          ns = 2; m_sisn = i_seq; m_win = i_win; m_ss = 1; end
                3'd2: if (i_dir && i_flags[4] && !i_flags[1]) begin ns = 3; m_win = i_win; m_se = 1; end
                3'd3: if (i_len != 0) ns = 4;
                default: ;
            endcase
        end
        m_vuln  = !rst_e && (expv || scan);
        m_cause = !m_vuln ? 2'd0 : (expv ? 2'd2 : 2'd1);
        if (ns != m_state || !(ns == 3'd1 || ns == 3'd2)) m_cnt = 0;
        else if (m_cnt != 16'hFFFF) m_cnt = m_cnt + 1;
        m_state = ns;
        if (i_v) begin m_div = i_dir; m_seq = i_seq; m_ttl = i_ttl; m_sa = i_sa; end
    endtask

    task automatic compare_all();
        chk(conn_state == m_state, "R7 state", conn_state, m_state);
        chk(established == (m_state >= 3'd3), "R4 established", established, m_state >= 3'd3);
        chk(flag_vuln == m_vuln, "R6 flag_vuln", flag_vuln, m_vuln);
        chk(vuln_cause == m_cause, "R8 vuln_cause", vuln_cause, m_cause);
        chk(ws_sr == m_ss && ws_est == m_se, "R3 strobes", {ws_sr, ws_est}, {m_ss, m_se});
        chk(peer_window == m_win, "R4 peer_window", peer_window, m_win);
        chk(client_isn == m_cisn && server_isn == m_sisn, "R2 isn", client_isn ^ server_isn, m_cisn ^ m_sisn);
        chk(division == m_div && c_seq == m_seq && c_ttl == m_ttl && c_sa == m_sa, "R10 context", c_seq, m_seq);
    endtask

    // Drive one cycle at a falling edge, then compare after the rising edge
    task automatic cyc(input logic v, input logic dir, input logic [5:0] fl,
                       input logic [31:0] seq, input logic [15:0] win, input logic [15:0] len);
        i_v = v; i_dir = dir; i_flags = fl; i_seq = seq; i_win = win; i_len = len;
        i_ack = seq + 32'd7; i_sa = seq ^ 32'hA5A5_0000; i_da = ~seq;
        i_sp = win + 16'd3; i_dp = len; i_ttl = seq[7:0];
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(); cyc(1'b0, 1'b0, 6'd0, 32'd0, 16'd0, 16'd0); endtask

    initial begin
        #(200000 * 8);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(conn_state == 0 && !established && !flag_vuln && vuln_cause == 0, "R1 reset", conn_state, 0);
        chk(peer_window == 0 && client_isn == 0 && server_isn == 0 && c_seq == 0 && !division, "R1 reset regs", c_seq, 0);

        cyc(1, 1, 6'h02, 32'd100, 16'd0, 16'd0);
        chk(conn_state == 1 && client_isn == 32'd100, "R2 client SYN", conn_state, 1);
        cyc(1, 1, 6'h12, 32'd555, 16'h9999, 16'd0);
        chk(conn_state == 1 && !flag_vuln, "R7 wrong side SYN-ACK", conn_state, 1);
        cyc(1, 0, 6'h12, 32'd500, 16'h1234, 16'd0);
        chk(conn_state == 2 && server_isn == 32'd500 && peer_window == 16'h1234 && ws_sr, "R3 SYN-ACK", peer_window, 16'h1234);
        idle();
        chk(!ws_sr && conn_state == 2, "R3 strobe one cycle", ws_sr, 0);
        cyc(1, 1, 6'h10, 32'd101, 16'h4321, 16'd0);
        chk(conn_state == 3 && established && ws_est && peer_window == 16'h4321, "R4 client ACK", peer_window, 16'h4321);
        cyc(1, 0, 6'h10, 32'd501, 16'h4000, 16'd0);
        chk(conn_state == 3 && !ws_est, "R5 zero length stays", conn_state, 3);
        chk(division == 0, "R10 division server", division, 0);
        cyc(1, 1, 6'h18, 32'd101, 16'h4000, 16'd10);
        chk(conn_state == 4 && established && division == 1, "R5 data enters exchange", conn_state, 4);
        cyc(1, 1, 6'h00, 32'd111, 16'h4000, 16'd0);
        chk(conn_state == 4 && flag_vuln && vuln_cause == 1, "R6 null scan", vuln_cause, 1);
        idle();
        chk(!flag_vuln && vuln_cause == 0, "R6 one-cycle alarm", flag_vuln, 0);
        cyc(1, 0, 6'h14, 32'd600, 16'd0, 16'd0);
        chk(conn_state == 0 && !established && !flag_vuln, "R9 reset segment", conn_state, 0);
        cyc(1, 1, 6'h01, 32'd7, 16'd0, 16'd0);
        chk(conn_state == 0 && flag_vuln && vuln_cause == 1, "R6 FIN scan", vuln_cause, 1);
        cyc(1, 1, 6'h03, 32'd8, 16'd0, 16'd0);
        chk(conn_state == 0 && flag_vuln && vuln_cause == 1, "R6 SYN-FIN scan", vuln_cause, 1);

        // R8 half-open timeout with limit 5
        cyc(1, 1, 6'h02, 32'd900, 16'd0, 16'd0);
        for (int k = 1; k < 5; k++) begin
            idle();
            chk(conn_state == 1, "R8 dwell", conn_state, 1);
        end
        idle();
        chk(conn_state == 0 && flag_vuln && vuln_cause == 2, "R8 expiry", vuln_cause, 2);
        idle();
        chk(!flag_vuln, "R8 expiry pulse", flag_vuln, 0);

        // R8 disabled timeout
        lim = 16'd0;
        cyc(1, 1, 6'h02, 32'd950, 16'd0, 16'd0);
        repeat (40) idle();
        chk(conn_state == 1 && !flag_vuln, "R8 limit zero disables", conn_state, 1);
        cyc(1, 0, 6'h04, 32'd0, 16'd0, 16'd0);
        chk(conn_state == 0, "R9 reset from half-open", conn_state, 0);

        // Random segment mix against the model
        lim = 16'd9;
        for (int n = 0; n < 6000; n++) begin
            logic [5:0] fl;
            int pick;
            pick = $urandom_range(0, 11);
            case (pick)
                0, 1: fl = 6'h02;
                2, 3: fl = 6'h12;
                4, 5: fl = 6'h10;
                6:    fl = 6'h18;
                7:    fl = 6'h11;
                8:    fl = 6'h04;
                9:    fl = 6'h00;
                10:   fl = 6'h01;
                default: fl = 6'($urandom);
            endcase
            cyc(($urandom_range(0, 9) < 6), $urandom_range(0, 1), fl, $urandom,
                16'($urandom), ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(1, 1400)));
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule